// File: doc/BRIEF.md
# Per-Event Strip Cluster Collector

This block sits behind the common-mode correction and hit detection of a silicon-strip readout board. For every event it takes the hit flags of one 128-strip front-end chip, one strip per accepted beat in the channel order of hit detection. It merges neighbouring hit strips into clusters and turns each cluster into one compact word. It then writes a record for the event into a downstream cluster FIFO. The record is a header word followed by the cluster words.

Clusters are held in a 64-entry local store while the event streams in. The header word can therefore carry the final cluster count and a flag that says whether the programmable cap dropped clusters. The record is emitted only once the FIFO reports room for all of it. While the block waits for room and while it writes the record, it holds off the input with `in_ready`, so a record is never split. The cap may be set from 0 to 64. The header also carries a running event number and a board identifier.

Top module: `cluster_collector`

## Requirements
- R1: After reset `in_ready` is 1, `fifo_wr` is 0, and the event number of the first record is 0.
- R2: A strip is consumed only on a cycle with `in_valid` and `in_ready` both high, and its index is the count of such beats since the start of the event (0 to 127). Beats with `in_valid` low are ignored whatever `in_hit` holds.
- R3: A cluster is a maximal run of consecutive hit strips. Its word has bit 24 = 0, bits 23:11 = 0, and bits 10:4 = the index of the run's lowest strip.
- R4: Bits 3:1 of a cluster word hold the run length when it is 7 or less, and 7 otherwise. Bit 0 is 1 exactly when the run is longer than 7.
- R5: The header word has bit 24 = 1, bits 23:12 = event number, bits 11:8 = `cfg_board`, bits 7:1 = number of cluster words that follow, and bit 0 = truncation flag.
- R6: A record is the header followed by its cluster words in ascending strip order, written with `fifo_wr` high on consecutive cycles.
- R7: Only the first L clusters of an event are forwarded, where L = `cfg_limit`, or 64 when `cfg_limit` exceeds 64. Later clusters are dropped, and the truncation flag is set when any cluster is dropped.
- R8: With L = 0 the record is a header alone with count 0. Its truncation flag is set when the event had any cluster.
- R9: After the last strip, `in_ready` stays low and nothing is written until `fifo_space` is at least count + 1. The whole record is then written, and `in_ready` returns to 1.
- R10: The event number increases by one for every record, modulo 4096.
- R11: A run reaching strip 127 is closed at the end of the event and never joins a run at the start of the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_limit | input | 7 | Cluster cap per event, values above 64 act as 64 |
| cfg_board | input | 4 | Board identifier copied into each header |
| in_valid | input | 1 | Strip beat valid |
| in_hit | input | 1 | Hit flag of the current strip |
| in_ready | output | 1 | Block accepts strip beats |
| fifo_space | input | 8 | Free words in the downstream FIFO |
| fifo_wr | output | 1 | Write strobe into the downstream FIFO |
| fifo_data | output | 25 | Header or cluster word |

## Verification
The hit patterns used are an empty event, a fully hit chip, alternating strips that give the theoretical maximum of 64 clusters, and regular runs of every length from 1 to 10. Together they separate the start-address logic, the clipping of the size field at 7 and the overflow bit. The same 64-cluster event is replayed with caps of 0, 1, 10, 64 and 100 to tell exact-limit, dropped-cluster and clamped-cap behaviour apart. A run ending on strip 127, followed by an event starting with a hit on strip 0, shows that runs do not join across events. A pseudo-random pattern with idle beats carrying a stray hit shows that beats without `in_valid` are ignored. An event offered one word too little FIFO room and then exactly enough shows the stall boundary.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int CC_NCH    = 128;
    localparam int CC_MAX_CL = 64;
    localparam int CC_EVT_W  = 12;
    localparam int CC_BRD_W  = 4;
    localparam int CC_SIZE_W = 3;

    typedef enum logic [1:0] {
        CC_COLLECT = 2'd0,
        CC_WAIT    = 2'd1,
        CC_EMIT    = 2'd2
    } cc_state_e;
endpackage

// File: rtl/cc_run_tracker.sv
// Follows runs of hit strips and reports each finished run for one cycle.
module cc_run_tracker #(
    parameter int NCH = 128,
    localparam int AW = $clog2(NCH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          hit,
    output logic          last,
    output logic          close_vld,
    output logic [AW-1:0] close_start,
    output logic [LW-1:0] close_len
);
    typedef struct packed {
        logic [AW-1:0] ch;
        logic          act;
        logic [AW-1:0] start;
        logic [LW-1:0] len;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        last        = (s_q.ch == AW'(NCH - 1));
        close_vld   = 1'b0;
        close_start = s_q.start;
        close_len   = s_q.len;
        if (step) begin
            if (hit) begin
                s_d.start = s_q.act ? s_q.start : s_q.ch;
                s_d.len   = s_q.act ? s_q.len + 1'b1 : LW'(1);
                s_d.act   = ~last;
                if (last) begin
                    close_vld   = 1'b1;
                    close_start = s_d.start;
                    close_len   = s_d.len;
                end
            end else begin
                close_vld = s_q.act;
                s_d.act   = 1'b0;
            end
            s_d.ch = last ? '0 : s_q.ch + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cc_stage_buf.sv
// Local store for the clusters of one event, written in order, read by index.
module cc_stage_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 11,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/cluster_collector.sv
module cluster_collector
    import cc_pkg::*;
#(
    parameter int NCH     = CC_NCH,
    parameter int MAX_CL  = CC_MAX_CL,
    parameter int EVT_W   = CC_EVT_W,
    parameter int BRD_W   = CC_BRD_W,
    parameter int SIZE_W  = CC_SIZE_W,
    localparam int AW     = $clog2(NCH),
    localparam int LW     = AW + 1,
    localparam int CNT_W  = $clog2(MAX_CL + 1),
    localparam int SPC_W  = CNT_W + 1,
    localparam int IW     = $clog2(MAX_CL),
    localparam int CLW    = AW + SIZE_W + 1,
    localparam int W      = 1 + EVT_W + BRD_W + CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic [BRD_W-1:0] cfg_board,
    input  logic             in_valid,
    input  logic             in_hit,
    output logic             in_ready,
    input  logic [SPC_W-1:0] fifo_space,
    output logic             fifo_wr,
    output logic [W-1:0]     fifo_data
);
    localparam int SMAX = (1 << SIZE_W) - 1;

    typedef struct packed {
        cc_state_e        st;
        logic [CNT_W-1:0] kept;
        logic             trunc;
        logic [CNT_W-1:0] idx;
        logic [EVT_W-1:0] evt;
    } ctl_t;

    ctl_t s_d, s_q;

    logic             step, last, close_vld, keep, ovf;
    logic [AW-1:0]    close_start;
    logic [LW-1:0]    close_len;
    logic [SIZE_W-1:0] size;
    logic [CNT_W-1:0] eff_lim;
    logic [CLW-1:0]   cl_word, rd_word;

    assign step = in_valid && in_ready;

    cc_run_tracker #(.NCH(NCH)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .hit        (in_hit),
        .last       (last),
        .close_vld  (close_vld),
        .close_start(close_start),
        .close_len  (close_len)
    );

    assign eff_lim = (cfg_limit > CNT_W'(MAX_CL)) ? CNT_W'(MAX_CL) : cfg_limit;
    assign keep    = close_vld && (s_q.kept < eff_lim);
    assign ovf     = close_len > LW'(SMAX);
    assign size    = ovf ? SIZE_W'(SMAX) : close_len[SIZE_W-1:0];
    assign cl_word = {close_start, size, ovf};

    cc_stage_buf #(.DEPTH(MAX_CL), .DW(CLW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (keep),
        .wr_addr(s_q.kept[IW-1:0]),
        .wr_data(cl_word),
        .rd_addr(IW'(s_q.idx - 1'b1)),
        .rd_data(rd_word)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            CC_COLLECT: begin
                if (keep) s_d.kept = s_q.kept + 1'b1;
                if (close_vld && !keep) s_d.trunc = 1'b1;
                if (step && last) s_d.st = CC_WAIT;
            end
            CC_WAIT: begin
                if (fifo_space >= ({1'b0, s_q.kept} + 1'b1)) begin
                    s_d.st  = CC_EMIT;
                    s_d.idx = '0;
                end
            end
            CC_EMIT: begin
                if (s_q.idx == s_q.kept) begin
                    s_d.st    = CC_COLLECT;
                    s_d.kept  = '0;
                    s_d.trunc = 1'b0;
                    s_d.evt   = s_q.evt + 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.st = CC_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= CC_COLLECT;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = (s_q.st == CC_COLLECT);
    assign fifo_wr   = (s_q.st == CC_EMIT);
    assign fifo_data = (s_q.idx == '0)
                     ? {1'b1, s_q.evt, cfg_board, s_q.kept, s_q.trunc}
                     : {1'b0, {(W - 1 - CLW){1'b0}}, rd_word};
endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
    parameter int MAX_CL = 64,
    parameter int CNT_W  = 7,
    parameter int SPC_W  = 8,
    parameter int SIZE_W = 3,
    parameter int W      = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_limit,
    input logic             in_ready,
    input logic [SPC_W-1:0] fifo_space,
    input logic             fifo_wr,
    input logic [W-1:0]     fifo_data
);
    logic [CNT_W-1:0]  lim;
    logic [CNT_W-1:0]  hdr_cnt;
    logic [SIZE_W-1:0] cl_size;
    logic              is_hdr;

    assign lim     = (cfg_limit > CNT_W'(MAX_CL)) ? CNT_W'(MAX_CL) : cfg_limit;
    assign hdr_cnt = fifo_data[CNT_W:1];
    assign cl_size = fifo_data[SIZE_W:1];
    assign is_hdr  = fifo_data[W-1];

    assert_count_capped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && is_hdr) |-> (hdr_cnt <= lim));

    assert_trunc_at_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && is_hdr && fifo_data[0]) |-> (hdr_cnt == lim));

    assert_ovf_clipped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !is_hdr && fifo_data[0]) |-> (cl_size == SIZE_W'((1 << SIZE_W) - 1)));

    assert_size_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !is_hdr) |-> (cl_size != '0));

    assert_header_leads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_wr) |-> is_hdr);

    assert_input_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && fifo_wr));

    assert_room_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fifo_wr) && $stable(fifo_space)) |-> (fifo_space > SPC_W'(hdr_cnt)));
endmodule

bind cluster_collector cc_checker #(
    .MAX_CL(MAX_CL),
    .CNT_W (CNT_W),
    .SPC_W (SPC_W),
    .SIZE_W(SIZE_W),
    .W     (W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_limit (cfg_limit),
    .in_ready  (in_ready),
    .fifo_space(fifo_space),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data)
);

// File: tb/sim_cluster_collector.sv
module sim_cluster_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_limit = 7'd64;
    logic [3:0]  cfg_board = 4'hA;
    logic        in_valid = 1'b0;
    logic        in_hit = 1'b0;
    logic        in_ready;
    logic [7:0]  fifo_space = 8'd255;
    logic        fifo_wr;
    logic [24:0] fifo_data;

    always #10 clk = ~clk;

    cluster_collector u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_limit (cfg_limit),
        .cfg_board (cfg_board),
        .in_valid  (in_valid),
        .in_hit    (in_hit),
        .in_ready  (in_ready),
        .fifo_space(fifo_space),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int got_n = 0;
    int evt_exp = 0;
    logic [24:0] got_w [0:127];
    int          got_c [0:127];
    logic [24:0] exp_w [0:64];
    int          exp_n;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (fifo_wr && got_n < 128) begin
            got_w[got_n] = fifo_data;
            got_c[got_n] = cyc;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Reference record built from the requirement text: scan for maximal runs.
    task automatic build_expect(input logic [127:0] hits, input int lim);
        int eff, cnt, ch, s, len, sz, ov;
        bit tr;
        eff = (lim > 64) ? 64 : lim;
        cnt = 0; tr = 0; ch = 0;
        while (ch < 128) begin
            if (hits[ch]) begin
                s = ch;
                while (ch < 128 && hits[ch]) ch++;
                len = ch - s;
                sz = (len > 7) ? 7 : len;
                ov = (len > 7) ? 1 : 0;
                if (cnt < eff) begin
                    exp_w[1 + cnt] = 25'((s << 4) | (sz << 1) | ov);
                    cnt++;
                end else begin
                    tr = 1;
                end
            end else begin
                ch++;
            end
        end
        exp_w[0] = 25'((1 << 24) | ((evt_exp % 4096) << 12) | (int'(cfg_board) << 8)
                   | (cnt << 1) | int'(tr));
        exp_n = cnt + 1;
    endtask

    task automatic run_event(input logic [127:0] hits, input int lim, input string tag,
                             input bit gaps, input bit hold);
        build_expect(hits, lim);
        got_n = 0;
        cfg_limit = 7'(lim);
        fifo_space = hold ? 8'(exp_n - 1) : 8'd255;
        for (int ch = 0; ch < 128; ch++) begin
            if (gaps && (ch % 5 == 0)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_hit = 1'b1;
            end
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_hit = hits[ch];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_hit = 1'b0;
        if (hold) begin
            repeat (20) @(negedge clk);
            chk(got_n == 0 && !in_ready, "R9", "stall with one word short", got_n, 0);
            fifo_space = 8'(exp_n);
        end
        while (!in_ready) @(negedge clk);
        chk(got_n == exp_n, tag, "record length", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (i == 0)
                chk(got_w[0] == exp_w[0], "R5/R10", "header word", got_w[0], exp_w[0]);
            else
                chk(got_w[i] == exp_w[i], tag, "cluster word", got_w[i], exp_w[i]);
            chk(got_c[i] == got_c[0] + i, "R6", "consecutive write", got_c[i], got_c[0] + i);
        end
        evt_exp++;
        fifo_space = 8'd255;
    endtask

    function automatic logic [127:0] runs(input int len, input int gap, input int first);
        logic [127:0] h = '0;
        int pos = first;
        while (pos < 128) begin
            for (int k = 0; k < len && pos + k < 128; k++) h[pos + k] = 1'b1;
            pos += len + gap;
        end
        return h;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R9: record never completed, actual hung expected done");
        report();
        $finish;
    end

    initial begin
        logic [127:0] alt, pat;
        logic [31:0] lf;
        alt = runs(1, 1, 0);
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && fifo_wr == 1'b0, "R1", "idle after reset",
            {in_ready, fifo_wr}, 2'b10);

        run_event('0, 64, "R3", 0, 0);
        run_event('1, 64, "R4", 0, 0);
        run_event(alt, 64, "R3", 0, 0);
        run_event(alt, 100, "R7", 0, 0);
        run_event(alt, 10, "R7", 0, 0);
        run_event(alt, 1, "R7", 0, 0);
        run_event(alt, 0, "R8", 0, 0);
        run_event('0, 0, "R8", 0, 0);
        for (int l = 1; l <= 10; l++) run_event(runs(l, 2, 1), 64, "R4", 0, 0);
        pat = '0;
        pat[127:120] = '1;
        pat[3] = 1'b1;
        run_event(pat, 64, "R11", 0, 0);
        run_event(128'h1, 64, "R11", 0, 0);
        cfg_board = 4'h5;
        lf = 32'hACE1_1234;
        for (int i = 0; i < 128; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            pat[i] = lf[0] & lf[3];
        end
        run_event(pat, 64, "R2", 1, 0);
        run_event(pat, 3, "R2", 1, 0);
        run_event(runs(2, 3, 0), 5, "R9", 0, 1);
        run_event(alt, 64, "R9", 0, 1);

        report();
        $finish;
    end
endmodule